// File: doc/BRIEF.md
# TDM Serial Receive Framer

This block sits at the receive edge of a time-slot switch. Eight serial lines each carry a frame of 32 eight-bit channels. The clock runs at twice the bit rate, so every data bit lasts two clock cycles. A single position counter tracks the current half-bit, bit and channel within the 512-cycle frame. An active-low frame pulse forces that counter back to the start of a frame.

Each line has its own shift register, and all eight are sampled together in the middle of every bit, most significant bit first. Once the eighth bit of a channel is in, the eight bytes are latched into a holding stage. During the next sixteen clocks they are written one at a time, on every second clock, into a 256-entry data memory. The address is the stream number above the channel number. The frame position is also brought out so the rest of the switch can follow the same frame timing.

Top module: `tdm_rx_framer`

## Requirements
- R1: While reset is held, `frame_pos` is 0 and `wr_en` is 0. After reset, `wr_en` stays 0 until the first complete channel has been sampled.
- R2: `frame_pos` is a 9-bit count of clock cycles within the frame. It rises by one every clock and wraps from 511 to 0 when no frame pulse is present.
- R3: A clock edge that samples `frame_n` low sets `frame_pos` to 0 for the next cycle, whatever its previous value. An early or late pulse gives no error indication. Bits resume with bit 7 of channel 0 at `frame_pos` 0.
- R4: `frame_pos[8:4]` is the channel, and `frame_pos[3:1]` is the bit slot, where slot 0 carries data bit 7 (MSB first). Each line is sampled at the clock edge that ends the cycle with `frame_pos[0]` = 0.
- R5: Every byte received on stream s in channel c is written with `wr_addr` = {s[2:0], c[4:0]}, so every one of the 256 locations is written exactly once per frame.
- R6: After channel c is sampled, stream 0 is written while `frame_pos[3:0]` = 15 of channel c. Stream k (1 to 7) is written while `frame_pos[3:0]` = 2k-1 of the following channel, so channel 31 completes in the next frame.
- R7: Once writing has begun, `wr_en` is high exactly in the cycles with `frame_pos[0]` = 1, and is never high in two cycles in a row.
- R8: The level of a data line during a cycle with `frame_pos[0]` = 1 has no effect on the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock at twice the line bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low one-clock frame alignment pulse |
| rx_line | input | 8 | Serial data, bit s is stream s |
| frame_pos | output | 9 | Cycle position within the frame: channel, bit slot, half-bit |
| wr_en | output | 1 | Data memory write strobe |
| wr_addr | output | 8 | Data memory address {stream, channel} |
| wr_data | output | 8 | Received byte to store |

## Verification
The assertions assume that `frame_n` is low for one clock at a time and that `rx_line` is driven to a known level from reset onward. The stimulus drives every input on the falling clock edge. It sends frame pulses only at frame boundaries, except for three directed cases: an early pulse, a dropped pulse and a late pulse. Write contents are compared only while the bench knows the frame alignment. They are not compared in the stretch after a forced resynchronisation, because the holding stage may still drain older bytes there, while position and strobe timing are checked in every cycle.

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer #(
  parameter int CHAN_W = 5,
  localparam int POS_W = CHAN_W + 4,
  localparam int ADDR_W = CHAN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [7:0]        rx_line,
  output logic [POS_W-1:0]  frame_pos,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam int LANES = 8;

  logic [POS_W-1:0]  cnt;
  logic [7:0]        shreg [LANES];
  logic [7:0]        hold  [LANES];
  logic [CHAN_W-1:0] hold_ch;
  logic              valid;

  wire       sample_now = ~cnt[0];
  wire       byte_done  = frame_n && (cnt[3:0] == 4'hE);
  wire [2:0] wsel       = cnt[3:1] + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!frame_n) cnt <= '0;
    else               cnt <= cnt + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      hold_ch <= '0;
      for (int s = 0; s < LANES; s++) begin
        shreg[s] <= '0;
        hold[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < LANES; s++) begin
        if (sample_now) shreg[s] <= {shreg[s][6:0], rx_line[s]};
        if (byte_done)  hold[s]  <= {shreg[s][6:0], rx_line[s]};
      end
      if (byte_done) begin
        hold_ch <= cnt[POS_W-1:4];
        valid   <= 1'b1;
      end
    end
  end

  assign frame_pos = cnt;
  assign wr_en     = valid & cnt[0];
  assign wr_addr   = {wsel, hold_ch};
  assign wr_data   = hold[wsel];

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && frame_pos != '1) |=> frame_pos == $past(frame_pos) + POS_W'(1));

  p_resync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_pos == '0);

  p_half_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_lane0_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[ADDR_W-1:CHAN_W] == 3'd0 && $past(frame_n))
      |-> wr_addr[CHAN_W-1:0] == frame_pos[POS_W-1:4]);

endmodule

// File: tb/tdm_rx_framer_tb.sv
module tdm_rx_framer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [7:0] rx_line = '0;
  logic [8:0] frame_pos;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  tdm_rx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .rx_line(rx_line),
    .frame_pos(frame_pos), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;
  logic [7:0] sent [2][8][32];
  int   pos = 0;
  bit   fpar = 1'b0;
  int   fidx = 0;
  bit   cap_seen = 1'b0;
  bit   skip = 1'b0;
  bit   dirty = 1'b1;
  bit   noisy = 1'b0;
  int   wcount = 0;

  localparam int MIS_EARLY = 9;
  localparam int DROP_AT   = 11;
  localparam int MIS_LATE  = 12;
  localparam int LAST      = 16;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d)", req, act, exp, pos);
    end
  endtask

  function automatic logic [7:0] pattern(input int s, input int c);
    return 8'((s << 5) | c) ^ 8'h96;
  endfunction

  function automatic int exp_stream(input int p);
    return ((p >> 1) + 1) & 7;
  endfunction

  function automatic int exp_chan(input int p);
    return ((p & 15) == 15) ? (p >> 4) : (((p >> 4) + 31) & 31);
  endfunction

  task automatic fill(input bit par, input bit directed);
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++)
        sent[par][s][c] = directed ? pattern(s, c) : 8'($urandom);
  endtask

  task automatic step();
    bit pulse;
    int es, ec;
    bit epar;
    chk(frame_pos == 9'(pos), "R2/R3 frame_pos", int'(frame_pos), pos);
    if (pos == 15) begin
      skip = 1'b0;
      if (!dirty) chk(wcount == 256, "R5 writes per frame", wcount, 256);
      dirty = 1'b0;
      wcount = 0;
    end
    if (cap_seen) chk(wr_en == pos[0], "R7 strobe phase", int'(wr_en), pos & 1);
    else          chk(wr_en == 1'b0, "R1 no write before first channel", int'(wr_en), 0);
    if (wr_en) begin
      wcount++;
      if (!skip) begin
        es = exp_stream(pos);
        ec = exp_chan(pos);
        epar = (ec == 31 && (pos >> 4) == 0) ? ~fpar : fpar;
        chk(int'(wr_addr[7:5]) == es, "R6 stream order", int'(wr_addr[7:5]), es);
        chk(int'(wr_addr[4:0]) == ec, "R5 channel field", int'(wr_addr[4:0]), ec);
        chk(wr_data == sent[epar][es][ec], "R4/R8 byte", int'(wr_data), int'(sent[epar][es][ec]));
      end
    end
    for (int s = 0; s < 8; s++)
      rx_line[s] = (noisy && pos[0]) ? 1'($urandom)
                                     : sent[fpar][s][pos >> 4][7 - ((pos >> 1) & 7)];
    pulse = (pos == 511 && fidx != DROP_AT) ||
            (fidx == MIS_EARLY && pos == 100) ||
            (fidx == MIS_LATE && pos == 50);
    frame_n = ~pulse;
    if (pulse && pos != 511) begin
      skip = 1'b1;
      dirty = 1'b1;
    end
    if (!pulse && (pos & 15) == 14) cap_seen = 1'b1;
    pos = pulse ? 0 : (pos + 1) % 512;
    if (pos == 0) begin
      fidx++;
      fpar = ~fpar;
      noisy = (fidx >= 3);
      fill(fpar, fidx < 3);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(frame_pos == 9'd0, "R1 reset frame_pos", int'(frame_pos), 0);
    chk(wr_en == 1'b0, "R1 reset wr_en", int'(wr_en), 0);
    rst_n = 1'b1;
    while (fidx < LAST) begin
      step();
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule